// File: doc/BRIEF.md
# Dual-Mode Byte DMA Controller

A single-channel engine that copies a block of bytes from a peripheral data port into main memory while the processor keeps its internal state. Software loads a destination address and a byte count through a small write-only register port, then writes a control word that picks the bus policy and starts the block. The engine asks for the system bus with `hold_req` and may drive the memory write port only while `hold_ack` is high.

Two bus policies exist. In burst policy the engine keeps the bus from the first byte to the last. In cycle-stealing policy it takes one byte per grant and lets go of the bus after each byte, so the processor can use the bus between bytes. The end of a block raises `irq`, which software clears. A block larger than the 16-bit count allows must be split into several programmed blocks, and each one ends with its own interrupt.

Top module: `bytemover_dma`

## Requirements
- R1: In burst policy (control bit 0 = 0), `hold_req` rises once per block and stays high from the first byte until the cycle that writes the last byte.
- R2: In cycle-stealing policy (control bit 0 = 1), each grant moves exactly one byte. `hold_req` is low in the cycle after every byte written, and it rises again once for each further byte.
- R3: `irq` goes high in the cycle after the last byte of a block is written and never after a single byte of a longer block. It stays high until a write to register select 3. If completion and clear fall in the same cycle, completion wins.
- R4: A block started with address A writes the addresses A, A+1, ... in ascending order, wrapping at the address width. `mem_wdata` carries `pdata`. Outside a held grant, `mem_addr` and `mem_wdata` are zero. A 1000-byte block at 7000 writes 7000 through 7999.
- R5: The count is 16 bits wide (select 1). A programmed count of 0 moves 65536 bytes.
- R6: `mem_we` and `pdata_take` are high together, and only in a cycle where `hold_req`, `hold_ack` and `pdata_valid` are all high during a block.
- R7: When `pdata_valid` is low, burst policy keeps `hold_req` high and writes nothing. Cycle-stealing policy leaves `hold_req` low until data is valid.
- R8: A start command (select 2, bit 1 = 1) is ignored while `busy` is high. Address and count writes (selects 0 and 1) made during a block do not change the running block.
- R9: A synchronous reset, sampled at a clock edge, leaves `hold_req`, `busy` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 interrupt clear |
| reg_wdata | input | DW | Register write data; control uses bit 0 as policy and bit 1 as start |
| pdata_valid | input | 1 | Peripheral byte available |
| pdata | input | BW | Peripheral byte |
| pdata_take | output | 1 | Peripheral byte consumed this cycle |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | BW | Memory write data |
| busy | output | 1 | A block is in progress |
| irq | output | 1 | Block-complete interrupt, held until cleared |

## Verification
A burst block of 1000 bytes at 7000 runs with a slow grant and a peripheral that stalls one cycle in three. This separates holding the bus through a gap in the data from releasing it. A 40-byte cycle-stealing block runs with steady data, and a fresh start command is issued in the middle of it. Counting the rising edges of `hold_req` then tells one request per byte apart from one request per block, and the write trace shows that the start was ignored. Short blocks in each policy with the data held off show how the request behaves while data is missing. A zero-count burst with an immediate grant checks the full 65536-byte length and the wrap of the address.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR    = 2'd0,
    SEL_COUNT   = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_IRQ_CLR = 2'd3
  } dmx_sel_e;

  localparam int CTRL_POLICY_BIT = 0;
  localparam int CTRL_GO_BIT     = 1;

  // Bytes in a block: a programmed zero stands for the full count range.
  function automatic int unsigned block_bytes(int unsigned programmed, int unsigned cnt_w);
    return (programmed == 32'd0) ? (32'd1 << cnt_w) : programmed;
  endfunction

endpackage

// File: rtl/dmx_cfg_regs.sv
module dmx_cfg_regs #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] cfg_addr,
  output logic [CW-1:0] cfg_cnt,
  output logic          go_req,
  output logic          go_policy,
  output logic          irq_clr
);
  import dmx_pkg::*;

  dmx_sel_e sel_e;
  assign sel_e = dmx_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr <= '0;
      cfg_cnt  <= '0;
    end else if (wr) begin
      if (sel_e == SEL_ADDR)  cfg_addr <= wdata[AW-1:0];
      if (sel_e == SEL_COUNT) cfg_cnt  <= wdata[CW-1:0];
    end
  end

  assign go_req    = wr && (sel_e == SEL_CTRL) && wdata[CTRL_GO_BIT];
  assign go_policy = wdata[CTRL_POLICY_BIT];
  assign irq_clr   = wr && (sel_e == SEL_IRQ_CLR);

endmodule

// File: rtl/dmx_xfer_cnt.sv
module dmx_xfer_cnt #(
  parameter int AW = 16,
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remain,
  output logic          last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      remain   <= remain - 1'b1;
    end
  end

  assign last = (remain == LW'(1));

endmodule

// File: rtl/dmx_bus_ctl.sv
module dmx_bus_ctl (
  input  logic clk,
  input  logic rst,
  input  logic go_req,
  input  logic go_policy,
  input  logic data_ok,
  input  logic grant,
  input  logic last,
  output logic busy,
  output logic steal,
  output logic hold_req,
  output logic accept,
  output logic fire,
  output logic done
);

  assign accept = go_req && !busy;
  assign fire   = busy && hold_req && grant && data_ok;
  assign done   = fire && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      steal    <= 1'b0;
      hold_req <= 1'b0;
    end else if (accept) begin
      busy     <= 1'b1;
      steal    <= go_policy;
      hold_req <= 1'b0;
    end else if (fire) begin
      if (last) begin
        busy     <= 1'b0;
        hold_req <= 1'b0;
      end else if (steal) begin
        hold_req <= 1'b0;
      end
    end else if (busy && !hold_req && (!steal || data_ok)) begin
      hold_req <= 1'b1;
    end
  end

endmodule

// File: rtl/bytemover_dma.sv
module bytemover_dma #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          pdata_valid,
  input  logic [BW-1:0] pdata,
  output logic          pdata_take,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  output logic          busy,
  output logic          irq
);
  import dmx_pkg::*;

  localparam int LW = CW + 1;

  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_cnt;
  logic          go_req, go_policy, irq_clr;
  logic [LW-1:0] load_len;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] remain;
  logic          last, steal, accept, fire, done, own;

  dmx_cfg_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .go_req(go_req),
    .go_policy(go_policy), .irq_clr(irq_clr)
  );

  assign load_len = LW'(block_bytes(32'(cfg_cnt), CW));

  dmx_xfer_cnt #(.AW(AW), .LW(LW)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .load_addr(cfg_addr),
    .load_len(load_len), .step(fire), .cur_addr(cur_addr),
    .remain(remain), .last(last)
  );

  dmx_bus_ctl u_bus (
    .clk(clk), .rst(rst), .go_req(go_req), .go_policy(go_policy),
    .data_ok(pdata_valid), .grant(hold_ack), .last(last), .busy(busy),
    .steal(steal), .hold_req(hold_req), .accept(accept), .fire(fire),
    .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (done)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  assign own        = hold_req && hold_ack;
  assign mem_we     = fire;
  assign pdata_take = fire;
  assign mem_addr   = own ? cur_addr : '0;
  assign mem_wdata  = own ? pdata : '0;

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
  parameter int AW = 16,
  parameter int LW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          pdata_valid,
  input logic          mem_we,
  input logic          busy,
  input logic          irq,
  input logic          steal,
  input logic          done,
  input logic [AW-1:0] cur_addr,
  input logic [LW-1:0] remain
);

  p_write_in_grant_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy && hold_ack && pdata_valid);

  p_release_each_byte_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we && steal |=> !hold_req);

  p_keep_bus_r1: assert property (@(posedge clk) disable iff (rst)
    mem_we && !steal && !done |=> hold_req);

  p_irq_at_end_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> irq && !busy);

  p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done));

  p_addr_ascends_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we && !done |=> cur_addr == AW'($past(cur_addr) + 1'b1));

  p_no_req_without_data_r7: assert property (@(posedge clk) disable iff (rst)
    busy && steal && !hold_req && !pdata_valid |=> !hold_req);

  p_len_live_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> remain != '0);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !hold_req && !irq && !busy);

endmodule

bind bytemover_dma dmx_checker #(.AW(AW), .LW(CW + 1)) u_chk (
  .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
  .pdata_valid(pdata_valid), .mem_we(mem_we), .busy(busy), .irq(irq),
  .steal(steal), .done(done), .cur_addr(cur_addr), .remain(remain)
);

// File: tb/test_bytemover_dma.sv
module test_bytemover_dma;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        pdata_valid = 1'b0;
  logic [7:0]  pdata = 8'd0;
  logic        pdata_take, hold_req, hold_ack, mem_we, busy, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  bytemover_dma i_bytemover_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pdata_valid(pdata_valid), .pdata(pdata),
    .pdata_take(pdata_take), .hold_req(hold_req), .hold_ack(hold_ack),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // stimulus knobs
  int grant_lat = 0;
  int vmode = 0;     // 0 always valid, 1 two of three, 2 never valid
  int ack_cnt = 0;
  int cyc = 0;
  int src_idx = 0;
  bit p_wr = 0;
  int p_sel = 0;
  int p_data = 0;
  bit p_rst = 1;

  // reference model state
  bit m_busy = 0, m_steal = 0, m_req = 0, m_irq = 0;
  int m_addr = 0, m_rem = 0, cfg_a = 0, cfg_c = 0;

  // observations
  int wr_cnt = 0, first_addr = -1, last_addr = -1, req_rises = 0, irq_rises = 0;
  bit prev_req = 0, prev_irq = 0;

  function automatic int src_byte(int i);
    return (i * 13 + 5) & 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL [%s] actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    wr_cnt = 0; first_addr = -1; last_addr = -1; req_rises = 0; irq_rises = 0;
  endtask

  task automatic tick();
    bit exp_we, own, fire;
    @(negedge clk);
    cyc++;
    rst = p_rst;
    if (hold_req) begin
      hold_ack = (ack_cnt >= grant_lat);
      ack_cnt++;
    end else begin
      hold_ack = 1'b0;
      ack_cnt = 0;
    end
    pdata_valid = (vmode == 0) ? 1'b1 : (vmode == 1) ? ((cyc % 3) != 0) : 1'b0;
    pdata = 8'(src_byte(src_idx));
    reg_wr = p_wr; reg_sel = 2'(p_sel); reg_wdata = 16'(p_data);
    #1;
    own = m_req && hold_ack;
    exp_we = m_busy && own && pdata_valid && !p_rst;
    if (!p_rst) begin
      check(hold_req == m_req, m_steal ? "R2 hold_req" : "R1 hold_req", int'(hold_req), int'(m_req));
      check(busy == m_busy, "R8 busy", int'(busy), int'(m_busy));
      check(irq == m_irq, "R3 irq", int'(irq), int'(m_irq));
      check(mem_we == exp_we, "R6 mem_we", int'(mem_we), int'(exp_we));
      check(pdata_take == exp_we, "R6 pdata_take", int'(pdata_take), int'(exp_we));
      check(int'(mem_addr) == (own ? m_addr : 0), "R4 mem_addr", int'(mem_addr), own ? m_addr : 0);
      check(int'(mem_wdata) == (own ? int'(pdata) : 0), "R4 mem_wdata", int'(mem_wdata), own ? int'(pdata) : 0);
    end
    if (mem_we) begin
      wr_cnt++;
      if (first_addr < 0) first_addr = int'(mem_addr);
      last_addr = int'(mem_addr);
    end
    if (hold_req && !prev_req) req_rises++;
    if (irq && !prev_irq) irq_rises++;
    prev_req = hold_req; prev_irq = irq;
    // model advance to the next edge
    if (p_rst) begin
      m_busy = 0; m_steal = 0; m_req = 0; m_irq = 0;
      m_addr = 0; m_rem = 0; cfg_a = 0; cfg_c = 0;
    end else begin
      bit was_busy;
      bit set_irq;
      was_busy = m_busy;
      set_irq = 0;
      fire = exp_we;
      if (fire) begin
        m_addr = (m_addr + 1) & 16'hFFFF;
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_req = 0; set_irq = 1;
        end else if (m_steal) m_req = 0;
      end else if (m_busy && !m_req && (!m_steal || pdata_valid)) m_req = 1;
      if (p_wr) begin
        case (p_sel)
          0: cfg_a = p_data & 16'hFFFF;
          1: cfg_c = p_data & 16'hFFFF;
          2: if (((p_data >> 1) & 1) == 1 && !was_busy) begin
               m_busy = 1; m_steal = bit'(p_data & 1); m_req = 0;
               m_addr = cfg_a; m_rem = (cfg_c == 0) ? 65536 : cfg_c;
             end
          default: if (!set_irq) m_irq = 0;
        endcase
      end
      if (set_irq) m_irq = 1;
    end
    if (exp_we) src_idx++;
    p_wr = 0;
  endtask

  task automatic wr(int sel, int data);
    p_wr = 1; p_sel = sel; p_data = data;
    tick();
  endtask

  task automatic run_block();
    while (m_busy) tick();
    repeat (3) tick();
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL [R1] watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    p_rst = 0;
    tick();
    // R9: quiet after reset
    check(!hold_req && !busy && !irq, "R9 reset state", int'({hold_req, busy, irq}), 0);

    // R1 and R4: burst, 1000 bytes at 7000, slow grant, stalling data
    grant_lat = 2; vmode = 1;
    wr(0, 7000); wr(1, 1000);
    clear_stats();
    wr(2, 2);
    run_block();
    check(wr_cnt == 1000, "R4 byte count", wr_cnt, 1000);
    check(first_addr == 7000, "R4 first address", first_addr, 7000);
    check(last_addr == 7999, "R4 last address", last_addr, 7999);
    check(req_rises == 1, "R1 one request per block", req_rises, 1);
    check(irq_rises == 1 && irq, "R3 single completion irq", irq_rises, 1);
    repeat (5) tick();
    check(irq == 1'b1, "R3 irq held", int'(irq), 1);
    wr(3, 0); tick();
    check(irq == 1'b0, "R3 irq cleared", int'(irq), 0);

    // R2 and R8: stealing, 40 bytes, start issued mid-block
    grant_lat = 1; vmode = 0;
    wr(0, 16'h0200); wr(1, 40);
    clear_stats();
    wr(2, 3);
    repeat (10) tick();
    wr(0, 16'h9000); wr(1, 7); wr(2, 2);
    run_block();
    check(req_rises == 40, "R2 one request per byte", req_rises, 40);
    check(wr_cnt == 40, "R8 running block unchanged", wr_cnt, 40);
    check(first_addr == 16'h0200 && last_addr == 16'h0227, "R8 address range kept", last_addr, 16'h0227);
    check(irq_rises == 1, "R3 no per-byte irq", irq_rises, 1);
    wr(3, 0);

    // R7: stealing with data held off
    vmode = 2;
    wr(0, 16'h3000); wr(1, 5);
    clear_stats();
    wr(2, 3);
    repeat (20) tick();
    check(req_rises == 0 && !hold_req, "R7 steal waits unrequested", req_rises, 0);
    vmode = 0;
    run_block();
    check(wr_cnt == 5, "R7 steal resumes", wr_cnt, 5);
    wr(3, 0);

    // R7: burst with data held off
    vmode = 2;
    wr(1, 3);
    clear_stats();
    wr(2, 2);
    repeat (20) tick();
    check(hold_req && wr_cnt == 0, "R7 burst holds bus idle", int'(hold_req), 1);
    vmode = 0;
    run_block();
    check(wr_cnt == 3, "R7 burst resumes", wr_cnt, 3);
    wr(3, 0);

    // R5: zero count moves 65536 bytes and wraps
    grant_lat = 0;
    wr(0, 16'h0100); wr(1, 0);
    clear_stats();
    wr(2, 2);
    run_block();
    check(wr_cnt == 65536, "R5 zero count length", wr_cnt, 65536);
    check(last_addr == 16'h00FF, "R5 wrapped last address", last_addr, 16'h00FF);
    check(irq_rises == 1, "R3 irq after full block", irq_rises, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule